// File: doc/BRIEF.md
# Virtual Interrupt List Bank

This block keeps a small bank of 32-bit list entries. Each entry describes one virtual interrupt for a single virtual CPU interface. A hypervisor fills and inspects the entries through a plain word-wide read/write port. Entry `n` sits at byte offset `0x100 + 4*n`. A configuration input sets how many entries are implemented, from none up to `N_ENT` (16 by default).

The virtual CPU side of the block has two ports:

- **Acknowledge port.** It picks the best pending entry, returns its virtual ID together with an optional requester-core number, and moves the entry to the active state.
- **Deactivate port.** It finds an active entry by its virtual ID and retires it. A hardware-linked entry sends a one-cycle physical deactivate request. A software entry raises an end-of-interrupt maintenance pulse if it asked for one.

Two registered interrupt lines, virtual IRQ and virtual FIQ, follow the pending entries. They are gated by the group enables and the FIQ routing input.

Entry layout:

| Bits | Content |
|------|---------|
| 31 | hardware-link flag |
| 30 | group |
| 29:28 | life-cycle state: 0 idle, 1 pending, 2 active, 3 active-and-pending |
| 27:23 | priority (lower value wins) |
| 22:20 | reserved, always read as zero |
| 19:10 | auxiliary field (see below) |
| 9:0 | virtual ID |

The auxiliary field has two uses:

- When the hardware-link flag is 1, it holds the physical interrupt ID.
- When the flag is 0, bit 19 requests the maintenance pulse, and bits 12:10 hold the requesting-core number.

Top module: `vlist_bank`

## Requirements
- R1: While `rst` is high, and after it falls, all entries read as zero. `virq`, `vfiq`, `ack_valid`, `pdeact_valid` and `eoi_maint` are low.
- R2: A bus write to `0x100 + 4*n`, with `n < cfg_count`, stores the word in entry `n`, except that bits 22:20 are forced to zero. A bus read of that address returns the entry on `bus_rdata` one clock after `bus_rd`.
- R3: Entries with index `n >= cfg_count` read as zero and ignore writes. Addresses outside `0x100 .. 0x100+4*N_ENT-1` also read as zero and ignore writes.
- R4: One cycle after `ack_req`, `ack_valid` pulses and `ack_id` holds the virtual ID of the winning entry.
  - Only entries in state 1 (pending) take part.
  - The lowest priority value wins; on a tie the lowest index wins.
  - The winning entry's state becomes 2 (active).
- R5: An acknowledge with no pending implemented entry returns `ack_id` = 1023 and changes no entry.
- R6: `ack_core` carries bits 12:10 of the selected entry when its virtual ID is below 16 and its hardware-link flag is 0. Otherwise it is 0.
- R7: A deactivate that matches an active entry (state 2 or 3) with the hardware-link flag set raises `pdeact_valid` for one cycle, with `pdeact_id` = entry bits 19:10, and no maintenance pulse. The entry moves from state 3 to 1, or from state 2 to 0.
- R8: A deactivate that matches an active entry with the hardware-link flag clear does three things:
  - it pulses `eoi_maint` for one cycle exactly when entry bit 19 is 1;
  - it never pulses `pdeact_valid`;
  - it makes the same state change as in R7.
- R9: A deactivate whose ID matches no implemented active entry changes no entry and raises no pulse. This includes an entry that is only pending.
- R10: `vfiq` is high one cycle after some implemented entry is pending in group 0 while both `en_grp0` and `fiq_route` are set. `virq` is high one cycle after either of these holds:
  - a group 0 entry is pending with `en_grp0` set and `fiq_route` clear;
  - a group 1 entry is pending with `en_grp1` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_count | input | 5 | Number of implemented entries |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| ack_req | input | 1 | Acknowledge request |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_id | output | 10 | Acknowledged virtual ID or 1023 |
| ack_core | output | 3 | Requesting core number |
| deact_req | input | 1 | Deactivate request |
| deact_id | input | 10 | Virtual ID to retire |
| pdeact_valid | output | 1 | Physical deactivate request pulse |
| pdeact_id | output | 10 | Physical interrupt ID |
| eoi_maint | output | 1 | End-of-interrupt maintenance pulse |
| en_grp0 | input | 1 | Group 0 signalling enable |
| en_grp1 | input | 1 | Group 1 signalling enable |
| fiq_route | input | 1 | Route group 0 as FIQ |
| virq | output | 1 | Virtual IRQ line |
| vfiq | output | 1 | Virtual FIQ line |

## Verification
The hardest cases are those where several entries compete, and where entries sit in the active-and-pending state. An acknowledge only ever produces the active state, so the bench puts such entries in place directly through bus writes, including an active-and-pending entry with the best priority, which must still be passed over. It then runs acknowledges in sequence so that both the priority rule and the index tie-break are seen, and reads the entries back to confirm each state change. Deactivates aimed at pending-only entries and at unknown IDs check that nothing moves.

// File: rtl/vlist_pkg.sv
package vlist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b10,
    ST_BOTH = 2'b11
  } lstate_t;

  localparam int PRIO_W = 5;
  localparam int ID_W   = 10;
  localparam int CORE_W = 3;

  typedef struct packed {
    logic              hw;
    logic              grp;
    lstate_t           st;
    logic [PRIO_W-1:0] prio;
    logic [2:0]        rsv;
    logic [ID_W-1:0]   aux;
    logic [ID_W-1:0]   vid;
  } lentry_t;

  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  // Clear reserved bits of an incoming word.
  function automatic lentry_t sanitize(input logic [31:0] w);
    lentry_t e;
    e = lentry_t'(w);
    e.rsv = 3'b000;
    return e;
  endfunction

  // Core number is reported only for software entries with a low ID.
  function automatic logic [CORE_W-1:0] core_of(input lentry_t e);
    if (!e.hw && (e.vid[ID_W-1:4] == '0)) return e.aux[CORE_W-1:0];
    return '0;
  endfunction

  // Next state after retirement of an active entry.
  function automatic lstate_t retire(input lstate_t s);
    return (s == ST_BOTH) ? ST_PEND : ST_IDLE;
  endfunction

endpackage

// File: rtl/vlist_sel.sv
module vlist_sel #(
  parameter int N  = 16,
  parameter int PW = 5,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][PW-1:0] prio,
  input  logic [N-1:0]         elig,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  logic [PW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig[i] && (!found || (prio[i] < best))) begin
        found = 1'b1;
        best  = prio[i];
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vlist_match.sv
module vlist_match #(
  parameter int N  = 16,
  parameter int DW = 10,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0][DW-1:0] vid,
  input  logic [N-1:0]         act,
  input  logic [DW-1:0]        key,
  output logic                 hit,
  output logic [IW-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = act[g] && (vid[g] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!hit && eq[i]) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/vlist_lines.sv
module vlist_lines #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pend_g0,
  input  logic [N-1:0] pend_g1,
  input  logic         en_grp0,
  input  logic         en_grp1,
  input  logic         fiq_route,
  output logic         virq,
  output logic         vfiq
);
  logic any0, any1;

  assign any0 = |pend_g0 && en_grp0;
  assign any1 = |pend_g1 && en_grp1;

  always_ff @(posedge clk) begin
    if (rst) begin
      virq <= 1'b0;
      vfiq <= 1'b0;
    end else begin
      vfiq <= any0 && fiq_route;
      virq <= (any0 && !fiq_route) || any1;
    end
  end
endmodule

// File: rtl/vlist_bank.sv
module vlist_bank #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 12,
  parameter int BASE   = 256,
  localparam int IW    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int CW    = $clog2(N_ENT + 1),
  localparam int IDW   = vlist_pkg::ID_W,
  localparam int PW    = vlist_pkg::PRIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW-1:0]     cfg_count,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ack_req,
  output logic              ack_valid,
  output logic [IDW-1:0]    ack_id,
  output logic [2:0]        ack_core,
  input  logic              deact_req,
  input  logic [IDW-1:0]    deact_id,
  output logic              pdeact_valid,
  output logic [IDW-1:0]    pdeact_id,
  output logic              eoi_maint,
  input  logic              en_grp0,
  input  logic              en_grp1,
  input  logic              fiq_route,
  output logic              virq,
  output logic              vfiq
);
  import vlist_pkg::*;

  localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(BASE + 4 * N_ENT);

  lentry_t [N_ENT-1:0] ent;

  logic [N_ENT-1:0]          impl, pend_m, act_m, pend_g0, pend_g1;
  logic [N_ENT-1:0][PW-1:0]  prio_v;
  logic [N_ENT-1:0][IDW-1:0] vid_v;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    assign impl[g]    = (CW'(g) < cfg_count);
    assign pend_m[g]  = impl[g] && (ent[g].st == ST_PEND);
    assign act_m[g]   = impl[g] && ent[g].st[1];
    assign pend_g0[g] = pend_m[g] && !ent[g].grp;
    assign pend_g1[g] = pend_m[g] && ent[g].grp;
    assign prio_v[g]  = ent[g].prio;
    assign vid_v[g]   = ent[g].vid;
  end

  // Bus decode: word aligned, inside window, implemented index.
  logic [ADDR_W-1:0] off;
  logic [IW-1:0]     bidx;
  logic              in_win, bus_ok;

  assign off    = bus_addr - WIN_LO;
  assign bidx   = off[IW+1:2];
  assign in_win = (bus_addr >= WIN_LO) && (bus_addr < WIN_HI) && (bus_addr[1:0] == 2'b00);
  assign bus_ok = in_win && impl[bidx];

  // Acknowledge selection and deactivate match.
  logic          sel_found, m_hit;
  logic [IW-1:0] sel_idx, m_idx;

  vlist_sel #(.N(N_ENT), .PW(PW)) u_sel (
    .prio  (prio_v),
    .elig  (pend_m),
    .found (sel_found),
    .idx   (sel_idx)
  );

  vlist_match #(.N(N_ENT), .DW(IDW)) u_match (
    .vid (vid_v),
    .act (act_m),
    .key (deact_id),
    .hit (m_hit),
    .idx (m_idx)
  );

  vlist_lines #(.N(N_ENT)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .pend_g0   (pend_g0),
    .pend_g1   (pend_g1),
    .en_grp0   (en_grp0),
    .en_grp1   (en_grp1),
    .fiq_route (fiq_route),
    .virq      (virq),
    .vfiq      (vfiq)
  );

  lentry_t sel_e, m_e;
  assign sel_e = ent[sel_idx];
  assign m_e   = ent[m_idx];

  // Entry storage and registered results. A bus write is applied last so it
  // overrides an acknowledge or deactivate update of the same entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      ent          <= '0;
      bus_rdata    <= '0;
      ack_valid    <= 1'b0;
      ack_id       <= '0;
      ack_core     <= '0;
      pdeact_valid <= 1'b0;
      pdeact_id    <= '0;
      eoi_maint    <= 1'b0;
    end else begin
      ack_valid    <= ack_req;
      pdeact_valid <= 1'b0;
      eoi_maint    <= 1'b0;

      if (ack_req) begin
        if (sel_found) begin
          ack_id            <= sel_e.vid;
          ack_core          <= core_of(sel_e);
          ent[sel_idx].st   <= ST_ACT;
        end else begin
          ack_id   <= SPURIOUS_ID;
          ack_core <= '0;
        end
      end

      if (deact_req && m_hit) begin
        ent[m_idx].st <= retire(m_e.st);
        if (m_e.hw) begin
          pdeact_valid <= 1'b1;
          pdeact_id    <= m_e.aux;
        end else begin
          eoi_maint <= m_e.aux[IDW-1];
        end
      end

      if (bus_wr && bus_ok) ent[bidx] <= sanitize(bus_wdata);

      if (bus_rd) bus_rdata <= bus_ok ? 32'(ent[bidx]) : 32'h0;
    end
  end
endmodule

// File: rtl/vlist_chk.sv
module vlist_chk #(
  parameter int N_ENT  = 16,
  parameter int ADDR_W = 12,
  parameter int BASE   = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              ack_req,
  input logic              ack_valid,
  input logic [9:0]        ack_id,
  input logic [2:0]        ack_core,
  input logic              deact_req,
  input logic              pdeact_valid,
  input logic              eoi_maint,
  input logic              en_grp0,
  input logic              en_grp1,
  input logic              fiq_route,
  input logic              virq,
  input logic              vfiq
);
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!virq && !vfiq && !ack_valid && !pdeact_valid && !eoi_maint));

  assert_rd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> (bus_rdata[22:20] == 3'b000));

  assert_outside_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && ((bus_addr < ADDR_W'(BASE)) || (bus_addr >= ADDR_W'(BASE + 4 * N_ENT))))
    |=> (bus_rdata == 32'h0));

  assert_ack_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    ack_req |=> ack_valid);

  assert_ack_only_req_R4: assert property (@(posedge clk) disable iff (rst)
    !ack_req |=> !ack_valid);

  assert_core_high_id_R6: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && (ack_id >= 10'd16)) |-> (ack_core == 3'd0));

  assert_pdeact_cause_R7: assert property (@(posedge clk) disable iff (rst)
    pdeact_valid |-> ($past(deact_req) && !eoi_maint));

  assert_eoi_cause_R8: assert property (@(posedge clk) disable iff (rst)
    eoi_maint |-> $past(deact_req));

  assert_fiq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    vfiq |-> $past(fiq_route && en_grp0));

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
    virq |-> $past(en_grp0 || en_grp1));

  assert_lines_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({virq, vfiq}) || $past(en_grp1));
endmodule

bind vlist_bank vlist_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_rd       (bus_rd),
  .bus_addr     (bus_addr),
  .bus_rdata    (bus_rdata),
  .ack_req      (ack_req),
  .ack_valid    (ack_valid),
  .ack_id       (ack_id),
  .ack_core     (ack_core),
  .deact_req    (deact_req),
  .pdeact_valid (pdeact_valid),
  .eoi_maint    (eoi_maint),
  .en_grp0      (en_grp0),
  .en_grp1      (en_grp1),
  .fiq_route    (fiq_route),
  .virq         (virq),
  .vfiq         (vfiq)
);

// File: tb/sim_vlist_bank.sv
`timescale 1ns/1ps
module sim_vlist_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  cfg_count = 5'd4;
  logic        bus_wr = 0, bus_rd = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ack_req = 0, ack_valid;
  logic [9:0]  ack_id;
  logic [2:0]  ack_core;
  logic        deact_req = 0;
  logic [9:0]  deact_id = '0;
  logic        pdeact_valid, eoi_maint;
  logic [9:0]  pdeact_id;
  logic        en_grp0 = 0, en_grp1 = 0, fiq_route = 0;
  logic        virq, vfiq;

  vlist_bank u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    string       tag;
    bit          is_rd;
    logic [31:0] rd;
    bit          av;
    logic [9:0]  aid;
    logic [2:0]  acore;
    bit          pv;
    logic [9:0]  pid;
    bit          eoi;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    total = 0, bad = 0;
  bit    done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: compares every output against the item due in this cycle.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      if (it.is_rd) chk(bus_rdata == it.rd, it.tag, "rdata", bus_rdata, it.rd);
      chk(ack_valid == it.av, it.tag, "ack_valid", ack_valid, it.av);
      if (it.av) begin
        chk(ack_id == it.aid, it.tag, "ack_id", ack_id, it.aid);
        chk(ack_core == it.acore, it.tag, "ack_core", ack_core, it.acore);
      end
      chk(pdeact_valid == it.pv, it.tag, "pdeact_valid", pdeact_valid, it.pv);
      if (it.pv) chk(pdeact_id == it.pid, it.tag, "pdeact_id", pdeact_id, it.pid);
      chk(eoi_maint == it.eoi, it.tag, "eoi_maint", eoi_maint, it.eoi);
    end
  end

  function automatic logic [31:0] mk(bit hw, bit g, logic [1:0] st, logic [4:0] pr,
                                     logic [9:0] aux, logic [9:0] vid);
    return {hw, g, st, pr, 3'b000, aux, vid};
  endfunction

  function automatic item_t blank(string tag);
    item_t it;
    it.due = cyc + 1; it.tag = tag; it.is_rd = 0; it.rd = '0;
    it.av = 0; it.aid = '0; it.acore = '0; it.pv = 0; it.pid = '0; it.eoi = 0;
    return it;
  endfunction

  task automatic finish_op();
    @(posedge clk); #1;
    bus_wr = 0; bus_rd = 0; ack_req = 0; deact_req = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    q.push_back(blank("write"));
    finish_op();
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    it = blank(tag); it.is_rd = 1; it.rd = exp;
    q.push_back(it);
    finish_op();
  endtask

  task automatic ack(input logic [9:0] id, input logic [2:0] core, input string tag);
    item_t it;
    @(negedge clk);
    ack_req = 1;
    it = blank(tag); it.av = 1; it.aid = id; it.acore = core;
    q.push_back(it);
    finish_op();
  endtask

  task automatic deact(input logic [9:0] id, input bit pv, input logic [9:0] pid,
                       input bit eoi, input string tag);
    item_t it;
    @(negedge clk);
    deact_req = 1; deact_id = id;
    it = blank(tag); it.pv = pv; it.pid = pid; it.eoi = eoi;
    q.push_back(it);
    finish_op();
  endtask

  task automatic lines(input bit g0, input bit g1, input bit fq,
                       input bit ei, input bit ef, input string tag);
    @(negedge clk);
    en_grp0 = g0; en_grp1 = g1; fiq_route = fq;
    repeat (2) @(negedge clk);
    chk(virq == ei, tag, "virq", virq, ei);
    chk(vfiq == ef, tag, "vfiq", vfiq, ef);
  endtask

  function automatic logic [11:0] ad(int n);
    return 12'(256 + 4 * n);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(!virq && !vfiq && !ack_valid && !pdeact_valid && !eoi_maint, "R1",
        "outputs in reset", {virq, vfiq, ack_valid, pdeact_valid, eoi_maint}, 0);
    rst = 0;
    rd(ad(0), 32'h0, "R1");
    rd(ad(3), 32'h0, "R1");

    // R2 store and readback, reserved bits cleared
    wr(ad(0), mk(0, 1, 2'd1, 5'd10, 10'd0, 10'd40));
    rd(ad(0), mk(0, 1, 2'd1, 5'd10, 10'd0, 10'd40), "R2");
    wr(ad(1), mk(0, 0, 2'd0, 5'd3, 10'd0, 10'd50) | 32'h0070_0000);
    rd(ad(1), mk(0, 0, 2'd0, 5'd3, 10'd0, 10'd50), "R2");

    // R3 unimplemented index and outside window
    wr(ad(5), 32'hFFFF_FFFF);
    rd(ad(5), 32'h0, "R3");
    wr(12'h0FC, 32'h1234_5678);
    rd(12'h0FC, 32'h0, "R3");
    rd(12'h200, 32'h0, "R3");
    cfg_count = 5'd6;
    rd(ad(5), 32'h0, "R3");
    cfg_count = 5'd4;

    // R4 selection: active-and-pending entry with best priority is skipped
    wr(ad(2), mk(0, 0, 2'd1, 5'd10, 10'd0, 10'd42));
    wr(ad(3), mk(0, 0, 2'd3, 5'd1, 10'd0, 10'd43));
    ack(10'd40, 3'd0, "R4");
    rd(ad(0), mk(0, 1, 2'd2, 5'd10, 10'd0, 10'd40), "R4");
    ack(10'd42, 3'd0, "R4");
    ack(10'd1023, 3'd0, "R5");
    rd(ad(3), mk(0, 0, 2'd3, 5'd1, 10'd0, 10'd43), "R5");
    wr(ad(2), mk(0, 0, 2'd1, 5'd2, 10'd0, 10'd42));
    wr(ad(1), mk(0, 0, 2'd1, 5'd7, 10'd0, 10'd41));
    ack(10'd42, 3'd0, "R4");
    ack(10'd41, 3'd0, "R4");

    // R6 core number
    wr(ad(0), mk(0, 0, 2'd1, 5'd0, 10'd5, 10'd5));
    ack(10'd5, 3'd5, "R6");
    wr(ad(0), mk(1, 0, 2'd1, 5'd0, 10'd37, 10'd5));
    ack(10'd5, 3'd0, "R6");
    wr(ad(0), mk(0, 0, 2'd1, 5'd0, 10'd3, 10'd20));
    ack(10'd20, 3'd0, "R6");

    // R7 hardware retire
    wr(ad(1), mk(1, 0, 2'd3, 5'd5, 10'd600, 10'd60));
    deact(10'd60, 1, 10'd600, 0, "R7");
    rd(ad(1), mk(1, 0, 2'd1, 5'd5, 10'd600, 10'd60), "R7");
    wr(ad(2), mk(1, 0, 2'd2, 5'd5, 10'd301, 10'd61));
    deact(10'd61, 1, 10'd301, 0, "R7");
    rd(ad(2), mk(1, 0, 2'd0, 5'd5, 10'd301, 10'd61), "R7");

    // R8 software retire with and without maintenance request
    wr(ad(3), mk(0, 0, 2'd2, 5'd5, 10'h200, 10'd62));
    deact(10'd62, 0, 10'd0, 1, "R8");
    wr(ad(3), mk(0, 0, 2'd2, 5'd5, 10'd0, 10'd63));
    deact(10'd63, 0, 10'd0, 0, "R8");
    rd(ad(3), mk(0, 0, 2'd0, 5'd5, 10'd0, 10'd63), "R8");

    // R9 no match
    deact(10'd99, 0, 10'd0, 0, "R9");
    deact(10'd60, 0, 10'd0, 0, "R9");
    rd(ad(1), mk(1, 0, 2'd1, 5'd5, 10'd600, 10'd60), "R9");

    // R10 interrupt lines
    for (int i = 0; i < 4; i++) wr(ad(i), 32'h0);
    wr(ad(0), mk(0, 0, 2'd1, 5'd0, 10'd0, 10'd7));
    lines(1, 0, 1, 0, 1, "R10");
    lines(1, 0, 0, 1, 0, "R10");
    lines(0, 1, 0, 0, 0, "R10");
    wr(ad(0), mk(0, 1, 2'd1, 5'd0, 10'd0, 10'd7));
    lines(0, 1, 1, 1, 0, "R10");
    lines(1, 0, 1, 0, 0, "R10");

    repeat (3) @(negedge clk);
    chk(q.size() == 0, "ALL", "queue drained", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule